// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns single register requests into clause-22 management frames on a two-wire MDC/MDIO link to an Ethernet PHY. A requester presents a read or write operation with a 5-bit PHY address, a register address and 16 bits of write data. The block then runs the whole frame by itself: a run of ones as preamble, the command bits, the turnaround, and the data phase. It raises a one-cycle done strobe when the frame is finished. For reads the 16-bit result is valid in that strobe cycle.

MDC is derived from the system clock. Each half period lasts a computed number of cycles, so the link never runs faster than the configured maximum rate. The block drives MDIO through a separate output and output-enable pair, and it releases the line whenever the PHY may drive it.

Read and write frames are built differently. A read shifts out a 16-bit header and then clocks in 19 released bits, of which only the 16 data bits are kept. A write shifts out a complete 32-bit word and follows it with two released clocks. A write that names a register above 31 is dropped without touching the wires.

Top module: `mdio_master`

## Requirements
- R1: While reset is held, and in the cycle after it, busy, done, mdc and mdio_oe are all 0.
- R2: During a frame, each MDC low phase and each MDC high phase lasts exactly HALF_CYC = ceil(CLK_MHZ*1000 / (2*MDC_MAX_KHZ)) system clocks. At the default parameters this is 20 clocks, or 200 ns at 100 MHz. MDC is 0 whenever no frame is running.
- R3: Every frame opens with PRE_BITS MDC periods (at least 32) in which mdio_oe is 1 and mdio_out is 1.
- R4: A read frame drives a 16-bit header after the preamble, most significant bit first. The header is 0xD800 | (phy << 5) | reg[4:0]. Register address bits above bit 4 do not affect a read.
- R5: After the read header, mdio_oe is 0 for 19 MDC periods and one mdio_in bit is sampled per period. Call the first sample s0 and the last s18. Then rdata[15] = s2 and rdata[0] = s17; the two turnaround samples and the trailing idle sample are discarded. rdata is valid in the done cycle.
- R6: A write frame drives 32 bits after the preamble, most significant bit first. The word is 0x50020000 | (phy << 23) | (reg[4:0] << 18) | wdata. Two more MDC periods follow with mdio_oe at 0.
- R7: A write whose register address has any bit above bit 4 set drives no frame. In that case done rises in the cycle right after acceptance, MDC produces no pulse, and mdio_oe stays 0.
- R8: mdio_out and mdio_oe change only while MDC is low; they never change during an MDC high phase. mdio_in is sampled at the clock edge on which MDC rises, after IN_SYNC synchronizer stages.
- R9: A request is accepted on an edge where req_valid is 1 and busy is 0. busy is 1 from the cycle after acceptance through the done cycle, and done lasts exactly one cycle. For a frame of T MDC periods, done is seen T*2*HALF_CYC cycles after the acceptance edge. A request presented while busy is dropped.
- R10: mdio_oe is 0 whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REGA_W | Register address; only bits 4:0 are sent |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Read result, valid with done |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_in | input | 1 | MDIO line value |

## Verification
Every frame result has a fixed due time. done is checked exactly 2*HALF_CYC*T cycles after the acceptance edge, where T is 67 MDC periods for a read and 66 for a write; for a dropped write it is checked in the very next cycle. The bench models the PHY. It captures mdio_out and mdio_oe on each MDC rise detected from the previous clock's value. It changes mdio_in one clock after each MDC fall, which leaves more than the synchronizer depth before the next sampling rise. Half-period lengths and changes during a high phase are counted on every clock. The bench compares these counts and the captured bits against values it computes itself, at the falling clock edge after done rises.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FRAME = 2'd1,
      SEQ_DONE  = 2'd2
   } seq_state_t;

   localparam int HDR_BITS   = 16;
   localparam int WORD_BITS  = 32;
   localparam int RD_IN_BITS = 19;
   localparam int WR_TAIL    = 2;

   function automatic logic [15:0] rd_header(input logic [4:0] phy, input logic [4:0] ra);
      return 16'hD800 | {6'b0, phy, ra};
   endfunction

   function automatic logic [31:0] wr_word(input logic [4:0] phy, input logic [4:0] ra,
                                           input logic [15:0] wd);
      return 32'h5002_0000 | {4'b0, phy, ra, 18'b0} | {16'b0, wd};
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_now,
   output logic fall_now
);
   localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          mdc_q;
   logic          wrap;

   assign wrap     = run && (cnt_q == LAST);
   assign rise_now = wrap && !mdc_q;
   assign fall_now = wrap && mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc_q);

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
   parameter int SYNC_STAGES = 0,
   parameter int CAP_BITS    = 19
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mdio_in,
   input  logic        sample_now,
   output logic [15:0] rdata
);
   logic din;
   logic [CAP_BITS-1:0] cap_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign din = mdio_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '1;
            end else begin
               sync_q[0] <= mdio_in;
               for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign din = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          cap_q <= '0;
      else if (sample_now) cap_q <= {cap_q[CAP_BITS-2:0], din};
   end

   // drop the trailing idle sample and the turnaround samples
   assign rdata = cap_q[16:1];

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_BITS = 32,
   parameter int REGA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [4:0]        req_phy,
   input  logic [REGA_W-1:0] req_reg,
   input  logic [15:0]       req_wdata,
   input  logic              rise_now,
   input  logic              fall_now,
   output logic              run,
   output logic              busy,
   output logic              done,
   output logic              sample_now,
   output logic              mdio_out,
   output logic              mdio_oe
);
   localparam int SR_W   = PRE_BITS + WORD_BITS;
   localparam int RD_TOT = PRE_BITS + HDR_BITS + RD_IN_BITS;
   localparam int WR_TOT = PRE_BITS + WORD_BITS + WR_TAIL;
   localparam int CW     = $clog2(RD_TOT + 1);
   localparam logic [CW-1:0] RD_LAST = CW'(RD_TOT - 1);
   localparam logic [CW-1:0] WR_LAST = CW'(WR_TOT - 1);
   localparam logic [CW-1:0] RD_DRV  = CW'(PRE_BITS + HDR_BITS - 1);
   localparam logic [CW-1:0] WR_DRV  = CW'(PRE_BITS + WORD_BITS - 1);
   localparam logic [CW-1:0] PRE_N   = CW'(PRE_BITS);

   seq_state_t      state_q;
   logic [SR_W-1:0] tx_q;
   logic [CW-1:0]   bit_q;
   logic            rd_q;
   logic            oe_q;
   logic            hi_bad;
   logic [CW-1:0]   last_idx;
   logic [CW-1:0]   drv_last;

   generate
      if (REGA_W > 5) begin : g_hi_chk
         assign hi_bad = |req_reg[REGA_W-1:5];
      end else begin : g_no_hi
         assign hi_bad = 1'b0;
      end
   endgenerate

   assign last_idx   = rd_q ? RD_LAST : WR_LAST;
   assign drv_last   = rd_q ? RD_DRV  : WR_DRV;
   assign run        = (state_q == SEQ_FRAME);
   assign busy       = (state_q != SEQ_IDLE);
   assign done       = (state_q == SEQ_DONE);
   assign sample_now = rise_now && rd_q && (bit_q > drv_last);
   assign mdio_oe    = oe_q;
   assign mdio_out   = oe_q & tx_q[SR_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         tx_q    <= '0;
         bit_q   <= '0;
         rd_q    <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  if (req_write && hi_bad) begin
                     state_q <= SEQ_DONE;
                  end else begin
                     state_q <= SEQ_FRAME;
                     oe_q    <= 1'b1;
                     bit_q   <= '0;
                     rd_q    <= !req_write;
                     if (req_write)
                        tx_q <= {{PRE_BITS{1'b1}}, wr_word(req_phy, req_reg[4:0], req_wdata)};
                     else
                        tx_q <= {{PRE_BITS{1'b1}}, rd_header(req_phy, req_reg[4:0]), 16'h0000};
                  end
               end
            end
            SEQ_FRAME: begin
               if (fall_now) begin
                  tx_q  <= tx_q << 1;
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == last_idx) begin
                     state_q <= SEQ_DONE;
                     oe_q    <= 1'b0;
                  end else if (bit_q == drv_last) begin
                     oe_q    <= 1'b0;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R10
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SEQ_FRAME) |-> !oe_q);

   // R3
   pre_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && bit_q < PRE_N) |-> (mdio_oe && mdio_out));

   // R9
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int CLK_MHZ     = 100,
   parameter int MDC_MAX_KHZ = 2500,
   parameter int PRE_BITS    = 32,
   parameter int REGA_W      = 8,
   parameter int IN_SYNC     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [4:0]        req_phy,
   input  logic [REGA_W-1:0] req_reg,
   input  logic [15:0]       req_wdata,
   output logic              busy,
   output logic              done,
   output logic [15:0]       rdata,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);
   localparam int HALF_CYC = (CLK_MHZ * 1000 + 2 * MDC_MAX_KHZ - 1) / (2 * MDC_MAX_KHZ);

   generate
      if (PRE_BITS < 32) begin : g_bad_pre
         $error("mdio_master: PRE_BITS must be at least 32");
      end
      if (REGA_W < 5) begin : g_bad_rega
         $error("mdio_master: REGA_W must be at least 5");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("mdio_master: MDC half period below one clock");
      end
      if (IN_SYNC > HALF_CYC - 2 && IN_SYNC != 0) begin : g_bad_sync
         $error("mdio_master: IN_SYNC too deep for the MDC half period");
      end
   endgenerate

   logic run, rise_now, fall_now, sample_now;

   mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .mdc      (mdc),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   mdio_frame_seq #(.PRE_BITS(PRE_BITS), .REGA_W(REGA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_phy    (req_phy),
      .req_reg    (req_reg),
      .req_wdata  (req_wdata),
      .rise_now   (rise_now),
      .fall_now   (fall_now),
      .run        (run),
      .busy       (busy),
      .done       (done),
      .sample_now (sample_now),
      .mdio_out   (mdio_out),
      .mdio_oe    (mdio_oe)
   );

   mdio_rx_capture #(.SYNC_STAGES(IN_SYNC), .CAP_BITS(mdio_pkg::RD_IN_BITS)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .mdio_in    (mdio_in),
      .sample_now (sample_now),
      .rdata      (rdata)
   );

   // R8
   sample_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_now |-> !mdc);

   // R8
   oe_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe != $past(mdio_oe)) |-> !mdc);

   // R8
   out_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_out));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
   localparam int H   = 4;
   localparam int PRE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_phy = '0;
   logic [7:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, mdc, mdio_out, mdio_oe;
   logic [15:0] rdata;
   logic        mdio_in = 1'b1;

   always #5 clk = ~clk;

   mdio_master #(.CLK_MHZ(100), .MDC_MAX_KHZ(12500), .PRE_BITS(PRE), .REGA_W(8), .IN_SYNC(2))
   u_mdio_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   int checks = 0;
   int errors = 0;

   // PHY model and line monitor
   logic        pat_rd = 1'b0;
   logic [15:0] pat_data = '0;
   logic        mdc_q = 1'b0, mdo_q = 1'b0, oe_q = 1'b0;
   int          run_len = 0;
   int          fr_rise = 0;
   int          fr_fall = 0;
   int          hp_viol = 0;
   int          chg_viol = 0;
   logic        cap_mdo [0:127];
   logic        cap_oe  [0:127];

   function automatic logic phy_bit(input int k);
      int j;
      j = k - (PRE + 16);
      if (!pat_rd || j < 0 || j > 18) return 1'b1;
      if (j == 0)  return 1'b1;
      if (j == 1)  return 1'b0;
      if (j == 18) return 1'b1;
      return pat_data[17 - j];
   endfunction

   always @(posedge clk) begin
      mdc_q <= mdc;
      mdo_q <= mdio_out;
      oe_q  <= mdio_oe;
      run_len <= (mdc != mdc_q) ? 1 : run_len + 1;
      if (mdc && mdc_q && (mdio_out != mdo_q || mdio_oe != oe_q)) chg_viol <= chg_viol + 1;
      if (!busy) begin
         fr_rise <= 0;
         fr_fall <= 0;
         mdio_in <= 1'b1;
      end else begin
         if (mdc && !mdc_q) begin
            cap_mdo[fr_rise[6:0]] <= mdio_out;
            cap_oe[fr_rise[6:0]]  <= mdio_oe;
            fr_rise <= fr_rise + 1;
            if (fr_rise != 0 && run_len != H) hp_viol <= hp_viol + 1;
         end
         if (!mdc && mdc_q) begin
            fr_fall <= fr_fall + 1;
            mdio_in <= phy_bit(fr_fall + 1);
            if (run_len != H) hp_viol <= hp_viol + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [4:0] phy, input logic [7:0] rg,
                       input logic [15:0] wd, input logic [15:0] rpat, input bit poke);
      int cyc;
      int hp0, cv0, tot, ones, oe_rel;
      bit ign;
      logic [31:0] got, exp;
      hp0 = hp_viol;
      cv0 = chg_viol;
      ign = wr && (rg[7:5] != 3'b000);
      pat_rd   = !wr;
      pat_data = rpat;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
      @(posedge clk);
      cyc = 0;
      forever begin
         @(negedge clk);
         req_valid = poke && (cyc == 100);
         req_write = 1'b1; req_reg = 8'h03;
         if (done || cyc > 5000) break;
         cyc++;
         if (!ign) chk(busy == 1'b1, "R9 busy during frame", busy, 1);
      end
      if (ign) begin
         chk(cyc == 0, "R7 ignored write done latency", cyc, 0);
         chk(fr_rise == 0, "R7 ignored write mdc pulses", fr_rise, 0);
         chk(mdio_oe == 1'b0, "R7 ignored write oe", mdio_oe, 0);
      end else begin
         tot = wr ? PRE + 34 : PRE + 35;
         chk(cyc == tot * 2 * H, "R9 done latency", cyc, tot * 2 * H);
         chk(fr_rise == tot, "R2 mdc pulse count", fr_rise, tot);
         ones = 0;
         for (int i = 0; i < PRE; i++) if (cap_mdo[i] && cap_oe[i]) ones++;
         chk(ones == PRE, "R3 preamble ones", ones, PRE);
         got = '0;
         if (wr) begin
            for (int i = 0; i < 32; i++) got = {got[30:0], cap_mdo[PRE + i] & cap_oe[PRE + i]};
            exp = 32'h5002_0000 + (32'(phy) << 23) + (32'(rg[4:0]) << 18) + 32'(wd);
            chk(got == exp, "R6 write word", got, exp);
            oe_rel = 0;
            for (int i = PRE + 32; i < PRE + 34; i++) if (cap_oe[i]) oe_rel++;
            chk(oe_rel == 0, "R6 released tail", oe_rel, 0);
         end else begin
            for (int i = 0; i < 16; i++) got = {got[30:0], cap_mdo[PRE + i] & cap_oe[PRE + i]};
            exp = 32'hD800 + (32'(phy) << 5) + 32'(rg[4:0]);
            chk(got == exp, "R4 read header", got, exp);
            oe_rel = 0;
            for (int i = PRE + 16; i < PRE + 35; i++) if (cap_oe[i]) oe_rel++;
            chk(oe_rel == 0, "R5 released read bits", oe_rel, 0);
            chk(rdata == rpat, "R5 read data", rdata, rpat);
         end
         chk(hp_viol == hp0, "R2 half period length", hp_viol - hp0, 0);
         chk(chg_viol == cv0, "R8 change while mdc high", chg_viol - cv0, 0);
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", done, 0);
      chk(busy == 1'b0, "R9 busy cleared", busy, 0);
      chk(mdio_oe == 1'b0, "R10 oe low when idle", mdio_oe, 0);
      chk(mdc == 1'b0, "R2 mdc low when idle", mdc, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         chk(busy == 1'b0 && fr_rise == 0, "R9 request during busy dropped", busy, 0);
      end
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 reset state",
          {busy, done, mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 after reset",
          {busy, done, mdc, mdio_oe}, 0);
      for (int r = 0; r < 32; r++)
         xfer(1'b0, 5'((r * 7 + 3) % 32), 8'(r), 16'h0, 16'((r * 16'h1357) ^ 16'hA5A5), r == 5);
      xfer(1'b0, 5'd17, 8'hE9, 16'h0, 16'h8001, 1'b0);
      xfer(1'b0, 5'd31, 8'h1F, 16'h0, 16'hFFFF, 1'b0);
      xfer(1'b0, 5'd0,  8'h00, 16'h0, 16'h0000, 1'b0);
      for (int r = 0; r < 32; r++)
         xfer(1'b1, 5'((r * 11 + 5) % 32), 8'(r), 16'(~(r * 16'h2468)), 16'h0, 1'b0);
      xfer(1'b1, 5'd9, 8'h20, 16'h1234, 16'h0, 1'b0);
      xfer(1'b1, 5'd9, 8'h45, 16'h1234, 16'h0, 1'b0);
      xfer(1'b1, 5'd9, 8'hFF, 16'h1234, 16'h0, 1'b0);
      xfer(1'b1, 5'd31, 8'h1F, 16'hFFFF, 16'h0, 1'b0);
   endtask

   initial begin
      bit wd_hit;
      wd_hit = 1'b0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 1 expected 0");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule